// File: doc/BRIEF.md
# Delay-Line Transition Phase Detector

This block sits at the digital end of a clock-recovery loop that follows a run-length-limited serial stream. An analog delay line, longer than one bit period and shorter than two, presents a vector of tap values. On every rising edge of the recovered clock the block registers that vector. It then finds the adjacent tap pair where the data changes level and decides whether the recovered clock needs to move. A change between the two middle taps means the loop is in phase, so no correction is issued. A change nearer the undelayed end produces a one-cycle `up` pulse. A change nearer the far end produces a one-cycle `dn` pulse. A bit period with no change produces nothing, which keeps the loop quiet during runs.

The recovered data bit is taken from the upper middle tap by a register clocked on the falling edge, half a period away from the transition. It is then retimed so that it leaves the block in the same cycle as the correction decision for the same sample set. A sample set with more than one level change cannot come from clean data, so it is reported as a glitch and produces no correction. A counter of consecutive silent sample sets raises a loss-of-activity flag once the run exceeds what the line code allows.

Top module: `tdl_phase_detector`

## Requirements
- R1: While `rst_n` is low, `up_o`, `dn_o`, `edge_seen_o`, `glitch_o`, `idle_o`, `rdata_o` and `rvalid_o` are all low, and the run counter restarts from zero.
- R2: A tap vector is registered on a rising edge, and the outputs computed from it appear after the following rising edge, two rising edges after the vector is presented. Bit i of `taps_i` is tap i, and tap 0 is the least delayed.
- R3: When exactly one adjacent pair differs and that pair is taps NTAPS/2-1 and NTAPS/2, `edge_seen_o` is high and both `up_o` and `dn_o` are low.
- R4: When exactly one pair (i, i+1) differs with i < NTAPS/2-1, `up_o` and `edge_seen_o` are high for that one cycle and `dn_o` is low.
- R5: When exactly one pair (i, i+1) differs with i > NTAPS/2-1, `dn_o` and `edge_seen_o` are high for that one cycle and `up_o` is low.
- R6: When all taps hold the same level, `up_o`, `dn_o`, `edge_seen_o` and `glitch_o` are low.
- R7: When two or more adjacent pairs differ, `glitch_o` is high and `up_o`, `dn_o` and `edge_seen_o` are low.
- R8: `up_o` and `dn_o` are never high in the same cycle, and each is decided afresh for every sample set, so it stays high for no longer than one cycle per set.
- R9: A run counter counts consecutive silent sample sets and saturates. `idle_o` is high while that count exceeds IDLE_LIMIT (default 5). Any set with at least one differing pair, a glitch included, clears the count and `idle_o` in that set's output cycle.
- R10: `rdata_o` carries tap NTAPS/2 as sampled on the falling edge inside the set's capture period, aligned with that set's correction outputs. `rvalid_o` goes high once a falling-edge sample has been taken since reset and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps_i | input | NTAPS | Delay-line tap levels, bit 0 least delayed |
| up_o | output | 1 | Advance pulse: edge found before the middle pair |
| dn_o | output | 1 | Retard pulse: edge found after the middle pair |
| edge_seen_o | output | 1 | Exactly one level change in the sample set |
| glitch_o | output | 1 | Two or more level changes in the sample set |
| idle_o | output | 1 | Silent run longer than IDLE_LIMIT sets |
| rdata_o | output | 1 | Recovered data bit |
| rvalid_o | output | 1 | Recovered data is valid |

## Verification
The assertions assume that the taps are stable over a whole clock period, so that the falling-edge sample and the next rising-edge capture see the same vector. They also assume that reset is released away from a clock edge. The stimulus changes `taps_i` only one nanosecond after a rising edge and releases reset at that same offset. Every vector is built as a clean step with one chosen change position, as a constant level, or as a deliberate two-change glitch. Because the vectors are built this way, the expected decision for each one follows directly from where the step was placed.

// File: rtl/tdlpd_pkg.sv
package tdlpd_pkg;

  // Decoded position of the level change in one registered sample set
  typedef struct packed {
    logic any;    // at least one adjacent pair differs
    logic one;    // exactly one adjacent pair differs
    logic early;  // first change sits before the middle pair
    logic late;   // first change sits after the middle pair
  } loc_t;

endpackage

// File: rtl/tdlpd_capture.sv
module tdlpd_capture #(
  parameter int NTAPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps_i,
  output logic [NTAPS-1:0] taps_q
);

  logic [NTAPS-1:0] taps_d;

  always_comb begin
    taps_d = taps_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
    end else begin
      taps_q <= taps_d;
    end
  end

endmodule

// File: rtl/tdlpd_locate.sv
module tdlpd_locate
  import tdlpd_pkg::*;
#(
  parameter int NTAPS = 8
) (
  input  logic [NTAPS-1:0] taps,
  output loc_t             res
);

  localparam int NPAIR = NTAPS - 1;
  localparam int CTR   = NTAPS / 2 - 1;
  localparam int IW    = $clog2(NTAPS);

  logic [NPAIR-1:0] diff;
  logic [IW-1:0]    first;

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      assign diff[g] = taps[g] ^ taps[g+1];
    end
  endgenerate

  // lowest differing pair index, scanned from the top so the lowest wins
  always_comb begin
    first = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (diff[i]) first = IW'(i);
    end
  end

  always_comb begin
    res.any   = |diff;
    res.one   = res.any && ((diff & (diff - 1'b1)) == '0);
    res.early = res.any && (first < IW'(CTR));
    res.late  = res.any && (first > IW'(CTR));
  end

endmodule

// File: rtl/tdlpd_steer.sv
module tdlpd_steer
  import tdlpd_pkg::*;
#(
  parameter int IDLE_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  loc_t res,
  output logic up_o,
  output logic dn_o,
  output logic edge_seen_o,
  output logic glitch_o,
  output logic idle_o
);

  localparam int SAT = IDLE_LIMIT + 1;
  localparam int CW  = $clog2(IDLE_LIMIT + 2);

  logic [CW-1:0] run_q, run_d;
  logic          up_d, dn_d, edge_d, glitch_d, idle_d;

  always_comb begin
    up_d     = res.one && res.early;
    dn_d     = res.one && res.late;
    edge_d   = res.one;
    glitch_d = res.any && !res.one;
    if (res.any) begin
      run_d = '0;
    end else if (run_q == CW'(SAT)) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
    idle_d = run_d > CW'(IDLE_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o        <= 1'b0;
      dn_o        <= 1'b0;
      edge_seen_o <= 1'b0;
      glitch_o    <= 1'b0;
      idle_o      <= 1'b0;
      run_q       <= '0;
    end else begin
      up_o        <= up_d;
      dn_o        <= dn_d;
      edge_seen_o <= edge_d;
      glitch_o    <= glitch_d;
      idle_o      <= idle_d;
      run_q       <= run_d;
    end
  end

  p_no_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  p_corr_has_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o || dn_o) |-> edge_seen_o);

  p_glitch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_o |-> (!up_o && !dn_o && !edge_seen_o));

  p_activity_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen_o || glitch_o) |-> !idle_o);

  p_idle_rise_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> (!edge_seen_o && !glitch_o));

endmodule

// File: rtl/tdlpd_retime.sv
module tdlpd_retime #(
  parameter int ALIGN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_tap,
  output logic rdata_o,
  output logic rvalid_o
);

  logic             neg_bit, neg_ok;
  logic [ALIGN-1:0] dat_q, val_q, dat_d, val_d;

  // mid-bit sample, opposite edge to the phase-locked rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_bit <= 1'b0;
      neg_ok  <= 1'b0;
    end else begin
      neg_bit <= mid_tap;
      neg_ok  <= 1'b1;
    end
  end

  generate
    if (ALIGN == 1) begin : g_one
      always_comb begin
        dat_d = neg_bit;
        val_d = neg_ok;
      end
    end else begin : g_many
      always_comb begin
        dat_d = {dat_q[ALIGN-2:0], neg_bit};
        val_d = {val_q[ALIGN-2:0], neg_ok};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      val_q <= '0;
    end else begin
      dat_q <= dat_d;
      val_q <= val_d;
    end
  end

  assign rdata_o  = dat_q[ALIGN-1];
  assign rvalid_o = val_q[ALIGN-1];

  p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> rvalid_o);

endmodule

// File: rtl/tdl_phase_detector.sv
module tdl_phase_detector
  import tdlpd_pkg::*;
#(
  parameter int NTAPS      = 8,
  parameter int IDLE_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             edge_seen_o,
  output logic             glitch_o,
  output logic             idle_o,
  output logic             rdata_o,
  output logic             rvalid_o
);

  localparam int MID = NTAPS / 2;

  logic [NTAPS-1:0] taps_q;
  loc_t             loc;

  tdlpd_capture #(.NTAPS(NTAPS)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .taps_i (taps_i),
    .taps_q (taps_q)
  );

  tdlpd_locate #(.NTAPS(NTAPS)) u_locate (
    .taps (taps_q),
    .res  (loc)
  );

  tdlpd_steer #(.IDLE_LIMIT(IDLE_LIMIT)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .res         (loc),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .edge_seen_o (edge_seen_o),
    .glitch_o    (glitch_o),
    .idle_o      (idle_o)
  );

  tdlpd_retime #(.ALIGN(2)) u_retime (
    .clk      (clk),
    .rst_n    (rst_n),
    .mid_tap  (taps_i[MID]),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

endmodule

// File: tb/tb_tdl_phase_detector.sv
`timescale 1ns/1ps
module tb_tdl_phase_detector;

  localparam int NT  = 8;
  localparam int LIM = 5;
  localparam int CTR = NT / 2 - 1;

  typedef struct {
    int   due;
    logic up, dn, edg, gl, idle, rd;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] taps = '0;
  logic          up, dn, edg, gl, idle, rd, rv;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   run_m = 2;  // two silent sets already decoded around reset release
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdl_phase_detector #(.NTAPS(NT), .IDLE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .taps_i(taps),
    .up_o(up), .dn_o(dn), .edge_seen_o(edg), .glitch_o(gl),
    .idle_o(idle), .rdata_o(rd), .rvalid_o(rv)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [NT-1:0] step(input int idx, input logic lvl);
    logic [NT-1:0] v;
    for (int j = 0; j < NT; j++) v[j] = (j <= idx) ? lvl : ~lvl;
    return v;
  endfunction

  // driver: presents one vector per cycle and predicts its outcome
  task automatic drive(input logic [NT-1:0] v);
    exp_t e;
    int   nd, fi;
    @(posedge clk);
    #1;
    taps = v;
    nd = 0; fi = -1;
    for (int j = 0; j < NT - 1; j++) begin
      if (v[j] != v[j+1]) begin
        nd++;
        if (fi < 0) fi = j;
      end
    end
    if (nd == 0) begin
      if (run_m < LIM + 1) run_m++;
    end else begin
      run_m = 0;
    end
    e.due  = cyc + 2;
    e.edg  = (nd == 1);
    e.up   = (nd == 1) && (fi < CTR);
    e.dn   = (nd == 1) && (fi > CTR);
    e.gl   = (nd > 1);
    e.idle = (run_m > LIM);
    e.rd   = v[NT/2];
    q.push_back(e);
  endtask

  // monitor: compares each prediction in the cycle its result appears
  always @(posedge clk) begin
    #3;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(up == e.up,    "R4 up_o",        up,  e.up);
      check(dn == e.dn,    "R5 dn_o",        dn,  e.dn);
      check(edg == e.edg,  "R3 edge_seen_o", edg, e.edg);
      check(gl == e.gl,    "R7 glitch_o",    gl,  e.gl);
      check(!(up && dn),   "R8 exclusive",   up && dn, 0);
      check(idle == e.idle,"R9 idle_o",      idle, e.idle);
      check(rd == e.rd,    "R10 rdata_o",    rd,  e.rd);
      check(rv == 1'b1,    "R10 rvalid_o",   rv,  1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check({up, dn, edg, gl, idle, rd, rv} == 7'b0, "R1 reset outputs",
          {up, dn, edg, gl, idle, rd, rv}, 0);
    rst_n = 1'b1;
    // R2 latency, R3 centre, R4 early, R5 late, both polarities
    drive(step(CTR, 1'b0));
    drive(step(CTR, 1'b1));
    for (int i = 0; i < NT - 1; i++) drive(step(i, 1'b0));
    for (int i = NT - 2; i >= 0; i--) drive(step(i, 1'b1));
    // R8: single-cycle pulses separated by silence
    drive(step(0, 1'b1));
    drive('0);
    drive(step(NT - 2, 1'b0));
    drive('1);
    // R7: glitches of different shapes
    drive(8'b0011_0000);
    drive(8'b0101_0101);
    drive(8'b1000_0001);
    // R6 / R9: silent runs, saturation and clearing
    for (int i = 0; i < LIM + 4; i++) drive('1);
    drive(step(CTR, 1'b1));
    for (int i = 0; i < LIM; i++) drive('0);
    drive('0);
    drive('0);
    drive(8'b0010_0100);  // R9: glitch counts as activity
    for (int i = 0; i < LIM + 1; i++) drive('1);
    drive(step(1, 1'b0));
    drive('0);
    drive('0);
    repeat (4) @(posedge clk);
    #4;
    check(q.size() == 0, "R2 all results seen", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule